// File: doc/BRIEF.md
# USB Device State Tracker

This block follows a USB function through the standard device states: attached, default, addressed, configured and suspended. It also shows whether the host is driving bus reset at that moment. It takes an attach/power level, a bus-reset level from the line-state decoder, a bus-activity pulse, a 1 ms tick and three firmware strobes: address done, set configured and clear configured. From these it keeps a 6-bit live status word. It also has an idle timer that moves the device into suspend after a set number of quiet milliseconds.

Any change of the live word raises a sticky change flag, which software clears by writing one to it. While the flag is clear, a snapshot copy of the status follows the live word one cycle behind. While the flag is set, the snapshot is frozen. Because of this, software that reads the snapshot for a pending event sees the state that caused the event. A bus reset that begins and ends while the event is still pending never shows up in the snapshot.

The configured bit drives a gate that admits traffic to endpoints other than endpoint 0. When that bit is clear, the gate is closed and status queries aimed at non-control endpoints are answered with a stall request. All pins are plain level or pulse signals with no handshake.

Top module: `usb_devstate_tracker`

## Requirements
- R1: After hardware reset, status bits 5..1 read 0, bit 0 equals `attach_i`, the change flag reads 0, `irq_o` reads 0 and the snapshot reads 0.
- R2: The status word is encoded as bit5 = bus reset active, bit4 = suspended, bit3 = configured, bit2 = addressed, bit1 = default and bit0 = attached. On the clock edge that samples `bus_reset_i`=1 with `attach_i`=1, bit5 and bit1 go to 1 and bits 4, 3 and 2 go to 0. On the first edge that samples `bus_reset_i`=0, bit5 returns to 0 and bit1 stays 1.
- R3: A bus reset does not clear a pending change flag.
- R4: The edge that samples `fw_addr_done_i`=1 while bit1=1 (and no bus reset) sets bit2. Bit2 then stays set until a bus reset or a detach. The strobe is ignored while bit1=0.
- R5: The edge that samples `fw_cfg_set_i`=1 while bit2=1 sets bit3. A set strobe while bit2=0 is ignored. `fw_cfg_clr_i` clears bit3, and it wins when both strobes are high in the same cycle.
- R6: `nonep0_gate_o` equals bit3, and `stall_req_o` equals `nonctl_status_req_i` AND NOT bit3. Both are combinational.
- R7: While bit1=1, the idle timer counts `tick_1ms_i` pulses. Bit4 sets on the edge that samples the IDLE_MS-th tick (default 5) counted since the last activity pulse or the end of bus reset. A tick sampled together with activity does not count.
- R8: An activity pulse sampled while bit4=1 clears bit4 on that edge and restarts the idle count.
- R9: While `attach_i`=0, bit0 reads 0 at once. The next edge clears bits 5..1 and the idle count. Bus reset is ignored while detached.
- R10: The change flag sets on the edge after any change of the live word, except on the first edge after reset. It stays set until an edge samples `chg_flag_clr_i`=1. If a change and the clear strobe arrive at the same edge, the set wins.
- R11: While the flag is clear, the snapshot loads the live word on every edge. The edge that sets the flag therefore captures the changed word, and the snapshot then holds that value for as long as the flag stays set.
- R12: `irq_o` is the change flag AND `chg_irq_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| attach_i | input | 1 | Device attached and powered (level) |
| bus_reset_i | input | 1 | Host driving bus reset (level) |
| bus_activity_i | input | 1 | Bus activity seen (pulse) |
| tick_1ms_i | input | 1 | One-millisecond tick (pulse) |
| fw_addr_done_i | input | 1 | Firmware: address assignment completed (strobe) |
| fw_cfg_set_i | input | 1 | Firmware: enter configured state (strobe) |
| fw_cfg_clr_i | input | 1 | Firmware: leave configured state (strobe) |
| nonctl_status_req_i | input | 1 | Status query aimed at a non-control endpoint |
| chg_irq_en_i | input | 1 | State-change interrupt enable |
| chg_flag_clr_i | input | 1 | Write-one-to-clear of the change flag |
| status_o | output | 6 | Live status word |
| status_snap_o | output | 6 | Snapshot of the status for software reads |
| chg_flag_o | output | 1 | Sticky state-change flag |
| irq_o | output | 1 | Interrupt request |
| nonep0_gate_o | output | 1 | Traffic to endpoints other than endpoint 0 allowed |
| stall_req_o | output | 1 | Stall the current non-control status query |

## Verification
A vector table walks the state machine through bus reset, addressing, the order of the configure and deconfigure strobes, quiet periods that do and do not reach the suspend limit, activity during suspend, and detach. This separates the effect of each strobe from the effect of the state that qualifies it. Directed sequences then hold the change flag pending across a complete bus-reset pulse, to show that the snapshot keeps the old value instead of copying the reset. They also make a change and a clear arrive at the same edge, to tell set-priority apart from clear-priority. The interrupt enable, the stall and gate outputs, and the reset values are checked directly at the pins.

// File: rtl/usb_devstate_pkg.sv
package usb_devstate_pkg;
  localparam int ST_W = 6;
  localparam int B_ATT = 0;
  localparam int B_DEF = 1;
  localparam int B_ADR = 2;
  localparam int B_CFG = 3;
  localparam int B_SUS = 4;
  localparam int B_RST = 5;

  typedef struct packed {
    logic bus_rst;
    logic susp;
    logic cfg;
    logic addr;
    logic dflt;
    logic att;
  } dev_status_t;
endpackage

// File: rtl/usbds_idle_timer.sv
module usbds_idle_timer #(
  parameter int IDLE_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic activity_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(IDLE_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last  = (cnt_q == LAST);
  assign expire_o = run_i & ~activity_i & tick_i & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i || activity_i) begin
      cnt_q <= '0;
    end else if (tick_i && !at_last) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/usbds_state_core.sv
module usbds_state_core
  import usb_devstate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        attach_i,
  input  logic        bus_reset_i,
  input  logic        activity_i,
  input  logic        expire_i,
  input  logic        addr_done_i,
  input  logic        cfg_set_i,
  input  logic        cfg_clr_i,
  output dev_status_t status_o
);
  logic rst_q, sus_q, cfg_q, adr_q, def_q;
  logic rst_d, sus_d, cfg_d, adr_d, def_d;

  always_comb begin
    rst_d = rst_q;
    sus_d = sus_q;
    cfg_d = cfg_q;
    adr_d = adr_q;
    def_d = def_q;
    if (!attach_i) begin
      rst_d = 1'b0;
      sus_d = 1'b0;
      cfg_d = 1'b0;
      adr_d = 1'b0;
      def_d = 1'b0;
    end else if (bus_reset_i) begin
      rst_d = 1'b1;
      def_d = 1'b1;
      adr_d = 1'b0;
      cfg_d = 1'b0;
      sus_d = 1'b0;
    end else begin
      rst_d = 1'b0;
      if (def_q && addr_done_i) adr_d = 1'b1;
      if (cfg_clr_i) cfg_d = 1'b0;
      else if (cfg_set_i && adr_q) cfg_d = 1'b1;
      if (sus_q && activity_i) sus_d = 1'b0;
      else if (expire_i) sus_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      sus_q <= 1'b0;
      cfg_q <= 1'b0;
      adr_q <= 1'b0;
      def_q <= 1'b0;
    end else begin
      rst_q <= rst_d;
      sus_q <= sus_d;
      cfg_q <= cfg_d;
      adr_q <= adr_d;
      def_q <= def_d;
    end
  end

  always_comb begin
    status_o.bus_rst = rst_q;
    status_o.susp    = sus_q;
    status_o.cfg     = cfg_q;
    status_o.addr    = adr_q;
    status_o.dflt    = def_q;
    status_o.att     = attach_i;
  end
endmodule

// File: rtl/usbds_change_notify.sv
module usbds_change_notify #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live_i,
  input  logic         clr_i,
  input  logic         en_i,
  output logic         flag_o,
  output logic         irq_o,
  output logic [W-1:0] snap_o
);
  logic         prime_q;
  logic         flag_q;
  logic [W-1:0] prev_q;
  logic [W-1:0] snap_q;
  logic         changed;

  assign changed = prime_q && (live_i != prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime_q <= 1'b0;
      prev_q  <= '0;
      flag_q  <= 1'b0;
      snap_q  <= '0;
    end else begin
      prime_q <= 1'b1;
      prev_q  <= live_i;
      if (changed) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
      if (!flag_q) snap_q <= live_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;
  assign snap_o = snap_q;
endmodule

// File: rtl/usb_devstate_tracker.sv
module usb_devstate_tracker
  import usb_devstate_pkg::*;
#(
  parameter int IDLE_MS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            attach_i,
  input  logic            bus_reset_i,
  input  logic            bus_activity_i,
  input  logic            tick_1ms_i,
  input  logic            fw_addr_done_i,
  input  logic            fw_cfg_set_i,
  input  logic            fw_cfg_clr_i,
  input  logic            nonctl_status_req_i,
  input  logic            chg_irq_en_i,
  input  logic            chg_flag_clr_i,
  output logic [ST_W-1:0] status_o,
  output logic [ST_W-1:0] status_snap_o,
  output logic            chg_flag_o,
  output logic            irq_o,
  output logic            nonep0_gate_o,
  output logic            stall_req_o
);
  dev_status_t st;
  logic        idle_run;
  logic        idle_expire;

  assign idle_run = attach_i & st.dflt & ~st.susp & ~bus_reset_i;

  usbds_idle_timer #(.IDLE_TICKS(IDLE_MS)) idle_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (idle_run),
    .activity_i (bus_activity_i),
    .tick_i     (tick_1ms_i),
    .expire_o   (idle_expire)
  );

  usbds_state_core core_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .attach_i    (attach_i),
    .bus_reset_i (bus_reset_i),
    .activity_i  (bus_activity_i),
    .expire_i    (idle_expire),
    .addr_done_i (fw_addr_done_i),
    .cfg_set_i   (fw_cfg_set_i),
    .cfg_clr_i   (fw_cfg_clr_i),
    .status_o    (st)
  );

  assign status_o = st;

  usbds_change_notify #(.W(ST_W)) notify_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .live_i (status_o),
    .clr_i  (chg_flag_clr_i),
    .en_i   (chg_irq_en_i),
    .flag_o (chg_flag_o),
    .irq_o  (irq_o),
    .snap_o (status_snap_o)
  );

  assign nonep0_gate_o = st.cfg;
  assign stall_req_o   = nonctl_status_req_i & ~st.cfg;
endmodule

// File: rtl/usb_devstate_tracker_chk.sv
module usb_devstate_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       attach_i,
  input logic       bus_reset_i,
  input logic       bus_activity_i,
  input logic       fw_cfg_set_i,
  input logic       fw_cfg_clr_i,
  input logic       chg_flag_clr_i,
  input logic [5:0] status_o,
  input logic [5:0] status_snap_o,
  input logic       chg_flag_o
);
  // R2
  busrst_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset_i && attach_i) |=> (status_o[5] && status_o[1] && !status_o[2]
                                   && !status_o[3] && !status_o[4]));

  // R9
  detach_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !attach_i |=> (status_o[5:1] == 5'd0));

  // R5
  cfg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[3]) |-> ($past(fw_cfg_set_i) && !$past(fw_cfg_clr_i)));

  // R8
  sus_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[4] && bus_activity_i && attach_i) |=> !status_o[4]);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag_o && !chg_flag_clr_i) |=> chg_flag_o);

  // R11
  snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_flag_o |=> $stable(status_snap_o));
endmodule

bind usb_devstate_tracker usb_devstate_tracker_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .attach_i       (attach_i),
  .bus_reset_i    (bus_reset_i),
  .bus_activity_i (bus_activity_i),
  .fw_cfg_set_i   (fw_cfg_set_i),
  .fw_cfg_clr_i   (fw_cfg_clr_i),
  .chg_flag_clr_i (chg_flag_clr_i),
  .status_o       (status_o),
  .status_snap_o  (status_snap_o),
  .chg_flag_o     (chg_flag_o)
);

// File: tb/usb_devstate_tracker_tb_top.sv
`timescale 1ns/1ps
module usb_devstate_tracker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic attach_i = 1'b0, bus_reset_i = 1'b0, bus_activity_i = 1'b0, tick_1ms_i = 1'b0;
  logic fw_addr_done_i = 1'b0, fw_cfg_set_i = 1'b0, fw_cfg_clr_i = 1'b0;
  logic nonctl_status_req_i = 1'b0, chg_irq_en_i = 1'b0, chg_flag_clr_i = 1'b0;
  logic [5:0] status_o, status_snap_o;
  logic chg_flag_o, irq_o, nonep0_gate_o, stall_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usb_devstate_tracker dut_i (.*);

  // entry: {attach, bus_reset, activity, tick, addr_done, cfg_set, cfg_clr} then expected status
  // status encoding: {bus_rst, susp, cfg, addr, dflt, att}
  localparam int NV = 30;
  localparam logic [12:0] VEC [NV] = '{
    {7'b1000000, 6'b000001}, {7'b1100000, 6'b100011}, {7'b1100000, 6'b100011},
    {7'b1000000, 6'b000011}, {7'b1000010, 6'b000011}, {7'b1000100, 6'b000111},
    {7'b1000010, 6'b001111}, {7'b1000011, 6'b000111}, {7'b1000010, 6'b001111},
    {7'b1001000, 6'b001111}, {7'b1001000, 6'b001111}, {7'b1010000, 6'b001111},
    {7'b1001000, 6'b001111}, {7'b1001000, 6'b001111}, {7'b1001000, 6'b001111},
    {7'b1001000, 6'b001111}, {7'b1001000, 6'b011111}, {7'b1010000, 6'b001111},
    {7'b1011000, 6'b001111}, {7'b1100000, 6'b100011}, {7'b1000000, 6'b000011},
    {7'b0000000, 6'b000000}, {7'b0100000, 6'b000000}, {7'b1000000, 6'b000001},
    {7'b1000100, 6'b000001}, {7'b1001000, 6'b000001}, {7'b1001000, 6'b000001},
    {7'b1001000, 6'b000001}, {7'b1001000, 6'b000001}, {7'b1001000, 6'b000001}
  };

  function automatic string vec_tag(int i);
    if (i == 4 || (i >= 6 && i <= 8)) return "R5";
    if (i == 5 || i == 24) return "R4";
    if ((i >= 9 && i <= 16) || i >= 25) return "R7";
    if (i == 17 || i == 18) return "R8";
    if (i >= 21 && i <= 23) return "R9";
    return "R2";
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(logic att);
    rst_n = 1'b0;
    attach_i = att;
    bus_reset_i = 1'b0; bus_activity_i = 1'b0; tick_1ms_i = 1'b0;
    fw_addr_done_i = 1'b0; fw_cfg_set_i = 1'b0; fw_cfg_clr_i = 1'b0;
    chg_flag_clr_i = 1'b0; chg_irq_en_i = 1'b0; nonctl_status_req_i = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 with detached device
    do_reset(1'b0);
    check("R1", "status detached", status_o, 6'b000000);
    check("R1", "flag", chg_flag_o, 1'b0);
    attach_i = 1'b1;
    step(); step();

    for (int i = 0; i < NV; i++) begin
      {attach_i, bus_reset_i, bus_activity_i, tick_1ms_i,
       fw_addr_done_i, fw_cfg_set_i, fw_cfg_clr_i} = VEC[i][12:6];
      step();
      check(vec_tag(i), $sformatf("vector %0d status", i), status_o, VEC[i][5:0]);
    end
    {attach_i, bus_reset_i, bus_activity_i, tick_1ms_i,
     fw_addr_done_i, fw_cfg_set_i, fw_cfg_clr_i} = 7'b1000000;

    // R1 attached reset
    do_reset(1'b1);
    check("R1", "status", status_o, 6'b000001);
    check("R1", "flag", chg_flag_o, 1'b0);
    check("R1", "irq", irq_o, 1'b0);
    check("R1", "snap", status_snap_o, 6'b000000);
    step(); step(); step();
    check("R10", "no change no flag", chg_flag_o, 1'b0);
    check("R11", "snap tracks", status_snap_o, 6'b000001);

    // R6 unconfigured
    nonctl_status_req_i = 1'b1;
    #1;
    check("R6", "stall unconfigured", stall_req_o, 1'b1);
    check("R6", "gate unconfigured", nonep0_gate_o, 1'b0);
    nonctl_status_req_i = 1'b0;

    // bus reset with flag clear: snapshot captures it
    bus_reset_i = 1'b1;
    step();
    check("R2", "reset live", status_o, 6'b100011);
    step();
    check("R10", "flag set", chg_flag_o, 1'b1);
    check("R11", "snap captures", status_snap_o, 6'b100011);
    bus_reset_i = 1'b0;
    step(); step();
    check("R11", "snap held", status_snap_o, 6'b100011);
    check("R3", "flag kept", chg_flag_o, 1'b1);
    check("R12", "irq disabled", irq_o, 1'b0);
    chg_irq_en_i = 1'b1;
    #1;
    check("R12", "irq enabled", irq_o, 1'b1);
    chg_irq_en_i = 1'b0;

    chg_flag_clr_i = 1'b1;
    step();
    chg_flag_clr_i = 1'b0;
    check("R10", "flag cleared", chg_flag_o, 1'b0);
    check("R11", "snap before refresh", status_snap_o, 6'b100011);
    step();
    check("R11", "snap refresh", status_snap_o, 6'b000011);

    // double buffering: pending flag hides a whole bus reset
    fw_addr_done_i = 1'b1;
    step();
    fw_addr_done_i = 1'b0;
    check("R4", "addressed", status_o, 6'b000111);
    step();
    check("R11", "snap addressed", status_snap_o, 6'b000111);
    bus_reset_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R11", "snap frozen in reset", status_snap_o, 6'b000111);
    end
    check("R3", "flag during reset", chg_flag_o, 1'b1);
    bus_reset_i = 1'b0;
    for (int k = 0; k < 2; k++) begin
      step();
      check("R11", "snap frozen after reset", status_snap_o, 6'b000111);
    end
    chg_flag_clr_i = 1'b1;
    step();
    chg_flag_clr_i = 1'b0;
    step();
    check("R10", "flag clear", chg_flag_o, 1'b0);
    check("R11", "snap after pending reset", status_snap_o, 6'b000011);

    // set wins over clear
    fw_addr_done_i = 1'b1;
    step();
    fw_addr_done_i = 1'b0;
    chg_flag_clr_i = 1'b1;
    step();
    chg_flag_clr_i = 1'b0;
    check("R10", "set beats clear", chg_flag_o, 1'b1);

    // R6 configured
    fw_cfg_set_i = 1'b1;
    step();
    fw_cfg_set_i = 1'b0;
    check("R5", "configured", status_o, 6'b001111);
    nonctl_status_req_i = 1'b1;
    #1;
    check("R6", "stall configured", stall_req_o, 1'b0);
    check("R6", "gate configured", nonep0_gate_o, 1'b1);
    nonctl_status_req_i = 1'b0;

    // R9 detach
    attach_i = 1'b0;
    #1;
    check("R9", "att drops at once", status_o[0], 1'b0);
    step();
    check("R9", "detached", status_o, 6'b000000);
    check("R9", "gate closed", nonep0_gate_o, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule